// File: doc/BRIEF.md
# Dead-Time Complementary Output Stage

This block turns one PWM reference into a pair of gate drives for the high and low switches of a half-bridge. The main output follows the reference and the complementary output follows its inverse. At every reference edge, the output that is about to turn on waits a programmable number of clock cycles after the other one has turned off, so the two switches never conduct together. A reference pulse shorter than that gap is swallowed.

Each output has its own polarity bit, so the active level can be high or low. The inactive level of each output is always the inverse of its active level, and that inactive level is also the safe idle level. A master gate, opened and closed by single-cycle set and clear pulses, must be open for either output to go active. A break pin forces both outputs to their idle levels combinationally, without waiting for a clock. Through a synchronizer, the same pin also closes the gate and latches a sticky trip flag. Software must clear the flag once the pin has gone low before the gate can be opened again.

Two state machines drive the block. The dead-band machine has four states:
- `DB_COMP_ON`: the complementary output is active.
- `DB_GAP_RISE`: both outputs are off, counting down before the main output turns on.
- `DB_MAIN_ON`: the main output is active.
- `DB_GAP_FALL`: both outputs are off, counting down before the complementary output turns on.

Its transitions are:
- From `DB_COMP_ON`, reference high goes to `DB_GAP_RISE`, or straight to `DB_MAIN_ON` when the dead time is zero.
- From `DB_GAP_RISE`, count done goes to `DB_MAIN_ON`, and reference low goes back to `DB_COMP_ON`.
- From `DB_MAIN_ON`, reference low goes to `DB_GAP_FALL`, or straight to `DB_COMP_ON` when the dead time is zero.
- From `DB_GAP_FALL`, count done goes to `DB_COMP_ON`, and reference high goes back to `DB_MAIN_ON`.

The gate machine has three states: `GT_OFF`, `GT_RUN` and `GT_TRIP`. Its transitions are:
- `GT_OFF` goes to `GT_RUN` on a set pulse.
- `GT_RUN` goes to `GT_OFF` on a clear pulse.
- `GT_OFF` and `GT_RUN` both go to `GT_TRIP` on a synchronized break.
- `GT_TRIP` goes to `GT_OFF` on a flag-clear pulse while the synchronized break is low.

Top module: `dtg_compl_out`

## Requirements
- R1: With the gate open and the reference steady, the main output is active while the reference is high and the complementary output is active while it is low, never both.
- R2: A reference rise that is first sampled at clock edge k turns the complementary output inactive after edge k. The main output then becomes active after edge k+D, where D is the dead_time value in cycles (1 to 255). Both outputs are inactive in between.
- R3: A reference fall that is first sampled at edge k turns the main output inactive after edge k, and the complementary output becomes active after edge k+D. Both outputs are inactive in between.
- R4: With dead_time equal to 0, both outputs change after edge k with no gap and no overlap.
- R5: A reference high pulse shorter than D cycles produces no active cycle on the main output. The complementary output returns to active when the pulse ends.
- R6: The two outputs are never active in the same cycle.
- R7: Polarity bit value 0 makes an output active-high and value 1 makes it active-low, independently for each output. The inactive and idle level of each output is the polarity bit value itself.
- R8: After reset the gate is closed, the flag is clear and both outputs sit at their idle levels. While the gate is closed both outputs stay idle. A set pulse opens the gate after the next edge, and a clear pulse closes it.
- R9: While brk_in is high, both outputs are at their idle levels at once, with no clock edge needed.
- R10: A break held for at least one cycle closes the gate and sets brk_flag_o within three clock edges. The flag stays set after the break ends, until a flag_clr pulse arrives while the synchronized break is low.
- R11: A set pulse while the flag is set leaves the gate closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | PWM reference, high means main switch on |
| dead_time | input | 8 | Dead time in clock cycles, 0 means no gap |
| pol_main | input | 1 | Main output polarity, 0 active-high, 1 active-low |
| pol_comp | input | 1 | Complementary output polarity, 0 active-high, 1 active-low |
| en_set | input | 1 | One-cycle pulse that opens the master gate |
| en_clr | input | 1 | One-cycle pulse that closes the master gate |
| flag_clr | input | 1 | One-cycle pulse that clears the trip flag |
| brk_in | input | 1 | Asynchronous break, active high |
| main_o | output | 1 | Main (high-side) drive |
| comp_o | output | 1 | Complementary (low-side) drive |
| out_en_o | output | 1 | Master gate state |
| brk_flag_o | output | 1 | Sticky trip flag |

## Verification
The checker watches several safety properties on every cycle:
- the two outputs are never active together;
- the break and the closed gate force idle levels;
- the flag cannot be set while the gate is open, and stays set until it is cleared;
- a nonzero gap precedes every turn-on.

The exact dead-band length is visible only in the bench's scenarios:
- the edge cycle at which each output turns on for a given dead time;
- the zero-delay case;
- the swallowing of a short pulse;
- the mixed polarity settings;
- the full sequence from trip through flag clear to re-enable.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    typedef enum logic [1:0] {
        DB_COMP_ON  = 2'd0,
        DB_GAP_RISE = 2'd1,
        DB_MAIN_ON  = 2'd2,
        DB_GAP_FALL = 2'd3
    } db_state_e;

    typedef enum logic [1:0] {
        GT_OFF  = 2'd0,
        GT_RUN  = 2'd1,
        GT_TRIP = 2'd2
    } gate_state_e;

    localparam int unsigned CH_MAIN = 0;
    localparam int unsigned CH_COMP = 1;
    localparam int unsigned CH_NUM  = 2;
endpackage

// File: rtl/dtg_deadband_fsm.sv
module dtg_deadband_fsm
    import dtg_pkg::*;
#(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_i,
    input  logic [DT_W-1:0] dt_i,
    output logic            main_act_o,
    output logic            comp_act_o
);
    localparam logic [DT_W-1:0] CNT_ZERO = '0;
    localparam logic [DT_W-1:0] CNT_ONE  = {{(DT_W-1){1'b0}}, 1'b1};

    db_state_e       state_q, state_d;
    logic [DT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_COMP_ON;
            cnt_q   <= CNT_ZERO;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DB_COMP_ON: begin
                if (ref_i) begin
                    if (dt_i == CNT_ZERO) begin
                        state_d = DB_MAIN_ON;
                    end else begin
                        state_d = DB_GAP_RISE;
                        cnt_d   = dt_i - CNT_ONE;
                    end
                end
            end
            DB_GAP_RISE: begin
                if (!ref_i) begin
                    state_d = DB_COMP_ON;
                end else if (cnt_q == CNT_ZERO) begin
                    state_d = DB_MAIN_ON;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            DB_MAIN_ON: begin
                if (!ref_i) begin
                    if (dt_i == CNT_ZERO) begin
                        state_d = DB_COMP_ON;
                    end else begin
                        state_d = DB_GAP_FALL;
                        cnt_d   = dt_i - CNT_ONE;
                    end
                end
            end
            DB_GAP_FALL: begin
                if (ref_i) begin
                    state_d = DB_MAIN_ON;
                end else if (cnt_q == CNT_ZERO) begin
                    state_d = DB_COMP_ON;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            default: begin
                state_d = DB_COMP_ON;
            end
        endcase
    end

    // outputs
    always_comb begin
        main_act_o = 1'b0;
        comp_act_o = 1'b0;
        unique case (state_q)
            DB_COMP_ON:  comp_act_o = 1'b1;
            DB_MAIN_ON:  main_act_o = 1'b1;
            DB_GAP_RISE,
            DB_GAP_FALL: begin
                main_act_o = 1'b0;
                comp_act_o = 1'b0;
            end
            default: begin
                main_act_o = 1'b0;
                comp_act_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dtg_gate_ctrl.sv
module dtg_gate_ctrl
    import dtg_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_i,
    input  logic en_set_i,
    input  logic en_clr_i,
    input  logic flag_clr_i,
    output logic gate_o,
    output logic flag_o
);
    localparam int unsigned SYNC_LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   brk_s;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= brk_i;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], brk_i};
            end
        end
    endgenerate

    assign brk_s = sync_q[SYNC_LAST];

    gate_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GT_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GT_OFF: begin
                if (brk_s)         state_d = GT_TRIP;
                else if (en_set_i) state_d = GT_RUN;
            end
            GT_RUN: begin
                if (brk_s)         state_d = GT_TRIP;
                else if (en_clr_i) state_d = GT_OFF;
            end
            GT_TRIP: begin
                if (flag_clr_i && !brk_s) state_d = GT_OFF;
            end
            default: state_d = GT_TRIP;
        endcase
    end

    // outputs
    always_comb begin
        gate_o = 1'b0;
        flag_o = 1'b0;
        unique case (state_q)
            GT_OFF:  begin gate_o = 1'b0; flag_o = 1'b0; end
            GT_RUN:  begin gate_o = 1'b1; flag_o = 1'b0; end
            GT_TRIP: begin gate_o = 1'b0; flag_o = 1'b1; end
            default: begin gate_o = 1'b0; flag_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/dtg_out_stage.sv
module dtg_out_stage (
    input  logic act_i,
    input  logic gate_i,
    input  logic brk_i,
    input  logic pol_i,
    output logic pin_o
);
    logic drive;

    always_comb begin
        drive = act_i & gate_i & ~brk_i;
        pin_o = drive ^ pol_i;
    end
endmodule

// File: rtl/dtg_compl_out.sv
module dtg_compl_out
    import dtg_pkg::*;
#(
    parameter int unsigned DT_W        = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_in,
    input  logic [DT_W-1:0] dead_time,
    input  logic            pol_main,
    input  logic            pol_comp,
    input  logic            en_set,
    input  logic            en_clr,
    input  logic            flag_clr,
    input  logic            brk_in,
    output logic            main_o,
    output logic            comp_o,
    output logic            out_en_o,
    output logic            brk_flag_o
);
    logic              main_act;
    logic              comp_act;
    logic              gate;
    logic [CH_NUM-1:0] ch_act;
    logic [CH_NUM-1:0] ch_pol;
    logic [CH_NUM-1:0] ch_pin;

    dtg_deadband_fsm #(.DT_W(DT_W)) u_band (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_i      (ref_in),
        .dt_i       (dead_time),
        .main_act_o (main_act),
        .comp_act_o (comp_act)
    );

    dtg_gate_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .brk_i      (brk_in),
        .en_set_i   (en_set),
        .en_clr_i   (en_clr),
        .flag_clr_i (flag_clr),
        .gate_o     (gate),
        .flag_o     (brk_flag_o)
    );

    assign ch_act[CH_MAIN] = main_act;
    assign ch_act[CH_COMP] = comp_act;
    assign ch_pol[CH_MAIN] = pol_main;
    assign ch_pol[CH_COMP] = pol_comp;

    generate
        for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
            dtg_out_stage u_stage (
                .act_i  (ch_act[c]),
                .gate_i (gate),
                .brk_i  (brk_in),
                .pol_i  (ch_pol[c]),
                .pin_o  (ch_pin[c])
            );
        end
    endgenerate

    assign main_o   = ch_pin[CH_MAIN];
    assign comp_o   = ch_pin[CH_COMP];
    assign out_en_o = gate;
endmodule

// File: rtl/dtg_compl_out_chk.sv
module dtg_compl_out_chk #(
    parameter int unsigned DT_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            brk_in,
    input logic            pol_main,
    input logic            pol_comp,
    input logic            main_o,
    input logic            comp_o,
    input logic            out_en_o,
    input logic            brk_flag_o,
    input logic            flag_clr,
    input logic            main_act,
    input logic            comp_act,
    input logic [DT_W-1:0] dead_time
);
    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((main_o ^ pol_main) && (comp_o ^ pol_comp)));

    // R9
    brk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_in |-> (main_o == pol_main && comp_o == pol_comp));

    // R8
    gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_o |-> (main_o == pol_main && comp_o == pol_comp));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag_o && !flag_clr) |=> brk_flag_o);

    // R11
    flag_blocks_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_flag_o |-> !out_en_o);

    // R2
    rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(main_act) && $past(dead_time) != '0) |-> $past(!comp_act));

    // R3
    fall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(comp_act) && $past(dead_time) != '0) |-> $past(!main_act));
endmodule

bind dtg_compl_out dtg_compl_out_chk #(.DT_W(DT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .brk_in     (brk_in),
    .pol_main   (pol_main),
    .pol_comp   (pol_comp),
    .main_o     (main_o),
    .comp_o     (comp_o),
    .out_en_o   (out_en_o),
    .brk_flag_o (brk_flag_o),
    .flag_clr   (flag_clr),
    .main_act   (main_act),
    .comp_act   (comp_act),
    .dead_time  (dead_time)
);

// File: tb/dtg_compl_out_tb.sv
`timescale 1ns/1ps
module dtg_compl_out_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic [7:0] dead_time = 8'd0;
    logic       pol_main = 1'b0;
    logic       pol_comp = 1'b0;
    logic       en_set = 1'b0;
    logic       en_clr = 1'b0;
    logic       flag_clr = 1'b0;
    logic       brk_in = 1'b0;
    logic       main_o, comp_o, out_en_o, brk_flag_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dtg_compl_out u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_in),
        .dead_time  (dead_time),
        .pol_main   (pol_main),
        .pol_comp   (pol_comp),
        .en_set     (en_set),
        .en_clr     (en_clr),
        .flag_clr   (flag_clr),
        .brk_in     (brk_in),
        .main_o     (main_o),
        .comp_o     (comp_o),
        .out_en_o   (out_en_o),
        .brk_flag_o (brk_flag_o)
    );

    function automatic logic m_act();
        return main_o ^ pol_main;
    endfunction

    function automatic logic c_act();
        return comp_o ^ pol_comp;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_set();
        en_set = 1'b1; @(negedge clk); en_set = 1'b0;
    endtask

    task automatic t_reset();
        chk(out_en_o == 1'b0, "R8 reset gate", out_en_o, 0);
        chk(brk_flag_o == 1'b0, "R8 reset flag", brk_flag_o, 0);
        chk(main_o == pol_main && comp_o == pol_comp, "R8 reset idle",
            {main_o, comp_o}, {pol_main, pol_comp});
        pulse_set();
        chk(out_en_o == 1'b1, "R8 gate opens", out_en_o, 1);
        chk(c_act() == 1'b1 && m_act() == 1'b0, "R1 ref low comp active",
            {m_act(), c_act()}, 1);
    endtask

    task automatic t_rise(input int dt);
        dead_time = dt[7:0];
        ref_in = 1'b0; cycles(dt + 4);
        ref_in = 1'b1;
        for (int j = 1; j <= dt + 1; j++) begin
            @(negedge clk);
            chk(c_act() == 1'b0, dt == 0 ? "R4 comp off" : "R2 comp off", c_act(), 0);
            chk(m_act() == (j == dt + 1), dt == 0 ? "R4 main timing" : "R2 main timing",
                m_act(), (j == dt + 1));
        end
        cycles(3);
        chk(m_act() == 1'b1 && c_act() == 1'b0, "R1 ref high main active",
            {m_act(), c_act()}, 2);
    endtask

    task automatic t_fall(input int dt);
        dead_time = dt[7:0];
        ref_in = 1'b1; cycles(dt + 4);
        ref_in = 1'b0;
        for (int j = 1; j <= dt + 1; j++) begin
            @(negedge clk);
            chk(m_act() == 1'b0, dt == 0 ? "R4 main off" : "R3 main off", m_act(), 0);
            chk(c_act() == (j == dt + 1), dt == 0 ? "R4 comp timing" : "R3 comp timing",
                c_act(), (j == dt + 1));
        end
    endtask

    task automatic t_short();
        int seen_main = 0;
        int seen_both = 0;
        dead_time = 8'd6;
        ref_in = 1'b0; cycles(10);
        ref_in = 1'b1; cycles(3);
        ref_in = 1'b0;
        for (int j = 0; j < 14; j++) begin
            @(negedge clk);
            if (m_act()) seen_main++;
            if (m_act() && c_act()) seen_both++;
        end
        chk(seen_main == 0, "R5 short pulse swallowed", seen_main, 0);
        chk(seen_both == 0, "R6 no overlap", seen_both, 0);
        chk(c_act() == 1'b1, "R5 comp back on", c_act(), 1);
    endtask

    task automatic t_polarity();
        dead_time = 8'd2;
        pol_main = 1'b1; pol_comp = 1'b0;
        ref_in = 1'b1; cycles(6);
        chk(main_o == 1'b0, "R7 main active-low driven", main_o, 0);
        chk(comp_o == 1'b0, "R7 comp inactive high-pol", comp_o, 0);
        pol_comp = 1'b1; #1;
        chk(comp_o == 1'b1, "R7 comp inactive low-pol", comp_o, 1);
        ref_in = 1'b0; cycles(6);
        chk(main_o == 1'b1 && comp_o == 1'b0, "R7 low-pol swap",
            {main_o, comp_o}, 1);
        en_clr = 1'b1; @(negedge clk); en_clr = 1'b0;
        chk(out_en_o == 1'b0, "R8 gate closes", out_en_o, 0);
        chk(main_o == 1'b1 && comp_o == 1'b1, "R8 idle low-pol",
            {main_o, comp_o}, 3);
        pol_main = 1'b0; pol_comp = 1'b0;
        pulse_set();
    endtask

    task automatic t_break();
        dead_time = 8'd1;
        ref_in = 1'b1; cycles(5);
        chk(m_act() == 1'b1, "R1 main active before break", m_act(), 1);
        #1 brk_in = 1'b1; #0.5;
        chk(main_o == pol_main && comp_o == pol_comp, "R9 immediate idle",
            {main_o, comp_o}, {pol_main, pol_comp});
        @(negedge clk); cycles(3);
        chk(brk_flag_o == 1'b1, "R10 flag set", brk_flag_o, 1);
        chk(out_en_o == 1'b0, "R10 gate closed", out_en_o, 0);
        brk_in = 1'b0; cycles(6);
        chk(brk_flag_o == 1'b1, "R10 flag sticky", brk_flag_o, 1);
        chk(main_o == pol_main, "R10 main idle after trip", main_o, pol_main);
        pulse_set(); cycles(1);
        chk(out_en_o == 1'b0, "R11 set ignored", out_en_o, 0);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk(brk_flag_o == 1'b0, "R10 flag cleared", brk_flag_o, 0);
        pulse_set();
        chk(out_en_o == 1'b1, "R8 re-enable", out_en_o, 1);
        chk(m_act() == 1'b1, "R1 main active again", m_act(), 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_rise(3);
        t_fall(3);
        t_rise(0);
        t_fall(0);
        t_rise(1);
        t_fall(7);
        t_short();
        t_polarity();
        t_break();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule